// File: doc/BRIEF.md
# Interrupt-Gated Transfer Time-out Watchdog

This block watches a byte-oriented two-wire serial controller for stalls. After each bus event the controller raises its interrupt flag and waits for software. While that flag is high, the watchdog's counter is held at zero. Once software clears the flag, the counter runs again from zero. If the counter gets all the way through its range before the next event, the watchdog sets a sticky time-out flag. It can also raise an interrupt request from that flag.

A prescale select makes the counter advance once every four clocks instead of every clock, which stretches the time-out period by a factor of four. Software clears the time-out flag with a write-1 strobe. Dropping the enable restarts the whole count but leaves the flag as it is.

Top module: `i2c_tmo_watchdog`

## Requirements
- R1: After reset, tmo_flag_o and irq_o are 0, and the counter and prescaler are at zero.
- R2: With en_i=1, div4_i=0 and si_i=0, the counter advances on every clock edge. tmo_flag_o rises on the 2**CNT_W-th edge after counting starts, when the counter wraps from all ones to zero. CNT_W defaults to 14.
- R3: While si_i=1, the counter is held at zero. After si_i returns to 0, a full 2**CNT_W edges pass before the flag sets.
- R4: With div4_i=1, the counter advances on every fourth counting edge. The period becomes 4*2**CNT_W edges. The prescaler restarts whenever si_i=1 or en_i=0.
- R5: tmo_flag_o is sticky. A one-cycle tmo_clr_i=1 clears it at the next clock edge.
- R6: irq_o equals tmo_flag_o AND irq_en_i (combinational).
- R7: en_i=0 resets the counter and the prescaler. It does not change tmo_flag_o.
- R8: If tmo_clr_i=1 in the same cycle as an expiry, tmo_flag_o is 1 afterwards.
- R9: After an expiry the counter keeps running from zero, so the next expiry comes 2**CNT_W edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Time-out counter enable |
| div4_i | input | 1 | 1 selects the divide-by-4 prescale |
| si_i | input | 1 | Controller interrupt flag level; holds the count at zero |
| tmo_clr_i | input | 1 | Write-1 strobe that clears the time-out flag |
| irq_en_i | input | 1 | Interrupt enable |
| tmo_flag_o | output | 1 | Sticky time-out flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that all inputs are synchronous to clk_i and stable around the rising edge. They also assume that tmo_clr_i is a single-cycle strobe issued by software. The stimulus changes every input only on falling edges. It uses the clear strobe for exactly one cycle, or together with si_i so that each trial starts from a counter at zero. The bench runs a small counter width, which lets it sweep every stall position across the whole count range and every prescaler phase.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int unsigned PRE_W = 2;
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  typedef enum logic {
    PRE_DIV1 = 1'b0,
    PRE_DIV4 = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/tmo_prescale.sv
module tmo_prescale
  import tmo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  pre_mode_e mode_i,
  output logic      tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    tick_o = 1'b0;
    if (run_i) tick_o = (mode_i == PRE_DIV1) ? 1'b1 : (pre_q == PRE_LAST);
  end

  // R4: in divide mode ticks are never back to back
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && mode_i == PRE_DIV4) |=> !tick_o);
  // R7 / R3: stopping restarts the phase
  a_r7_pre_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/tmo_count.sv
module tmo_count #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == CNT_MAX);

  // R3: held at zero while gated
  a_r3_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  // R2: a tick advances by exactly one
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9: wrap returns to zero
  a_r9_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
  // R2: no tick, no movement while running
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  // R8: set dominates clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R5: sticky without a clear
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R5: clear without set empties the flag
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/i2c_tmo_watchdog.sv
module i2c_tmo_watchdog
  import tmo_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div4_i,
  input  logic si_i,
  input  logic tmo_clr_i,
  input  logic irq_en_i,
  output logic tmo_flag_o,
  output logic irq_o
);
  logic      run;
  logic      tick;
  logic      expire;
  pre_mode_e mode;

  assign run  = en_i & ~si_i;
  assign mode = div4_i ? PRE_DIV4 : PRE_DIV1;

  tmo_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mode_i (mode),
    .tick_o (tick)
  );

  tmo_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick),
    .expire_o (expire)
  );

  tmo_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (tmo_clr_i),
    .flag_o (tmo_flag_o)
  );

  assign irq_o = tmo_flag_o & irq_en_i;

  // R6: request only with enable and flag
  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && tmo_flag_o));
  // R3 / R7: a gated cycle can never raise a new flag
  a_r3_no_set_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !tmo_flag_o) |=> !tmo_flag_o);
  // R1: flag and request clear while reset is held
  always_comb if (!rst_ni) a_r1_reset: assert (!irq_o);
endmodule

// File: tb/i2c_tmo_watchdog_tb.sv
`timescale 1ns/1ps
module i2c_tmo_watchdog_tb;
  localparam int unsigned W = 5;
  localparam int P = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, div4 = 1'b0, si = 1'b0, clr = 1'b0, irq_en = 1'b0;
  logic flag, irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_tmo_watchdog #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div4_i(div4), .si_i(si),
    .tmo_clr_i(clr), .irq_en_i(irq_en), .tmo_flag_o(flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp);
    check(flag === exp, req, int'(flag), int'(exp));
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // clear flag and zero the count in one cycle
  task automatic fresh();
    si = 1'b1; clr = 1'b1;
    edges(1);
    si = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    check(flag === 1'b0 && irq === 1'b0, "R1 reset", int'({flag, irq}), 0);
    rst_n = 1'b1;
    edges(2);
    chk_flag("R1 idle after reset", 1'b0);

    // R2 exact expiry, R6 gating
    en = 1'b1;
    edges(P - 1);
    chk_flag("R2 before expiry", 1'b0);
    edges(1);
    chk_flag("R2 at expiry", 1'b1);
    check(irq === 1'b0, "R6 irq masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    check(irq === 1'b1, "R6 irq enabled", int'(irq), 1);
    irq_en = 1'b0; #1;
    check(irq === 1'b0, "R6 irq disabled again", int'(irq), 0);

    // R9 continuous run after expiry, R5 clear
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    chk_flag("R5 cleared", 1'b0);
    edges(P - 2);
    chk_flag("R9 before second expiry", 1'b0);
    edges(1);
    chk_flag("R9 second expiry", 1'b1);

    // R5 sticky while held
    si = 1'b1;
    edges(40);
    chk_flag("R5 sticky", 1'b1);
    si = 1'b0;
    fresh();

    // R3 sweep of stall position
    for (int p = 1; p < P; p++) begin
      edges(p);
      chk_flag("R3 pre-stall", 1'b0);
      si = 1'b1;
      edges(1 + p % 3);
      si = 1'b0;
      edges(P - 1);
      chk_flag("R3 no early expiry", 1'b0);
      edges(1);
      chk_flag("R3 full period after release", 1'b1);
      fresh();
    end

    // R8 clear meets expiry
    edges(P - 1);
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    chk_flag("R8 set wins", 1'b1);

    // R7 disable keeps flag, restarts count
    en = 1'b0;
    edges(50);
    chk_flag("R7 flag kept when disabled", 1'b1);
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    chk_flag("R5 clear while disabled", 1'b0);
    en = 1'b1;
    edges(20);
    en = 1'b0;
    edges(1);
    en = 1'b1;
    edges(P - 1);
    chk_flag("R7 count restarted", 1'b0);
    edges(1);
    chk_flag("R7 expiry after restart", 1'b1);
    fresh();

    // R4 divide-by-4 over every prescaler phase
    div4 = 1'b1;
    for (int p = 0; p < 8; p++) begin
      if (p > 0) edges(p);
      si = 1'b1;
      edges(1);
      si = 1'b0;
      edges(4 * P - 1);
      chk_flag("R4 before expiry", 1'b0);
      edges(1);
      chk_flag("R4 at expiry", 1'b1);
      fresh();
    end
    // R4 / R7 disable restarts prescaler phase
    edges(6);
    en = 1'b0;
    edges(1);
    en = 1'b1;
    edges(4 * P - 1);
    chk_flag("R4 prescaler restart by enable", 1'b0);
    edges(1);
    chk_flag("R4 expiry after enable restart", 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule